// File: doc/BRIEF.md
# Dataflow Synchronization Slot Bank

This block holds a bank of synchronization slots that decide when a codelet may be enabled. Each slot keeps three values. The first is a count of dependency signals still outstanding. The second is a reload value. The third is the identity of the codelet it is bound to, given as a frame identifier plus a codelet identifier.

Producers send dependency signals that name a slot, and each accepted signal lowers that slot's count by one. When the count drops from one to zero, the slot holds an enable event naming its codelet. The event leaves on a valid/ready stream. When the codelet later starts running, a start notification for the slot reloads its count, so the same codelet can fire again. Several slots may name the same codelet, and each counts on its own.

On the output stream, `en_valid` may rise whenever any slot holds an event. While `en_valid` is high and `en_ready` is low, the offered event stays the same: slot, frame id and codelet id do not change. The one exception is a configuration write to the offered slot, which discards its event. An event is removed on the clock edge where `en_valid` and `en_ready` are both high. Back-pressure never stops the inputs: dependency signals, start notifications and configuration writes are taken on every cycle.

Top module: `sync_slot_bank`

## Requirements
- R1: After reset no slot is valid, `en_valid` is 0 and `err_pulse` is 0.
- R2: A configuration write (`cfg_we`) to slot `cfg_idx` marks the slot valid. It loads the count from `cfg_sync`, the reload value from `cfg_reset`, and the frame and codelet identifiers, and it discards any pending event of that slot. A dependency signal or start to the same slot in the same cycle is discarded without an error.
- R3: A dependency signal (`sig_valid`, `sig_idx`) to a valid slot with a nonzero count lowers the count by one. When the count goes from 1 to 0, the next cycle offers an event with `en_slot` equal to the slot index and `en_fid`/`en_cid` equal to the slot's identifiers.
- R4: A dependency signal is dropped, leaving the slot unchanged, if the slot is invalid, if its count is 0, or if its count is 1 while its earlier event is still pending. A drop makes `err_pulse` high for exactly the next cycle.
- R5: A start (`start_valid`, `start_idx`) to a valid slot reloads its count from the reload value, and a start to an invalid slot has no effect. A start and a dependency signal to the same slot in the same cycle apply the reload first and then the decrement, so a reload value of 1 fires at once.
- R6: Slots bound to the same codelet count and fire independently, each offering its own event.
- R7: While `en_valid` is high and `en_ready` is low, the offered event is held unchanged, and dependency signals are still counted. On the cycle after a handshake, the accepted event is gone.
- R8: When no event is being held under back-pressure, the lowest-numbered slot with a pending event is offered. A held event keeps precedence over a lower-numbered slot that fires later.
- R9: A slot configured with a count of 0 offers no event and drops dependency signals until a start reloads it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Slot written |
| cfg_sync | input | 8 | Initial outstanding count |
| cfg_reset | input | 8 | Reload value |
| cfg_fid | input | 8 | Frame identifier of the bound codelet |
| cfg_cid | input | 6 | Codelet identifier |
| sig_valid | input | 1 | Dependency signal strobe |
| sig_idx | input | 4 | Slot the dependency signal targets |
| start_valid | input | 1 | Codelet start notification strobe |
| start_idx | input | 4 | Slot to reload |
| en_valid | output | 1 | Enable event offered |
| en_ready | input | 1 | Consumer accepts the event |
| en_slot | output | 4 | Slot that produced the event |
| en_fid | output | 8 | Frame identifier of the enabled codelet |
| en_cid | output | 6 | Codelet identifier of the enabled codelet |
| err_pulse | output | 1 | One-cycle flag for a dropped dependency signal |

## Verification
Directed sequences cover several patterns:
- Plain countdown to zero, which separates correct decrementing from off-by-one firing.
- Signals to invalid, already-zero and still-pending slots, which separate the three drop causes from real decrements.
- Same-cycle start plus signal, which exposes the wrong reload/decrement order.
- Two slots naming one codelet fired under a stalled consumer, which tells the hold rule apart from plain lowest-index choice.

A long random run with small counts and a random `en_ready` is then compared each cycle against a behavioural model. It mixes collisions of configuration, start and signal on one slot.

// File: rtl/sync_bank_pkg.sv
package sync_bank_pkg;
  localparam int unsigned SB_SLOTS = 16;
  localparam int unsigned SB_CNT_W = 8;
  localparam int unsigned SB_FID_W = 8;
  localparam int unsigned SB_CID_W = 6;
endpackage

// File: rtl/sync_slot.sv
module sync_slot #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned FID_W = 8,
  parameter int unsigned CID_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_hit,
  input  logic [CNT_W-1:0] cfg_sync,
  input  logic [CNT_W-1:0] cfg_reset,
  input  logic [FID_W-1:0] cfg_fid,
  input  logic [CID_W-1:0] cfg_cid,
  input  logic             sig_hit,
  input  logic             start_hit,
  input  logic             grant,
  output logic             pend,
  output logic [FID_W-1:0] fid,
  output logic [CID_W-1:0] cid,
  output logic             drop
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             valid_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] rld_q;
  logic [FID_W-1:0] fid_q;
  logic [CID_W-1:0] cid_q;
  logic             pend_q;
  logic [CNT_W-1:0] eff;
  logic             take;

  // reload is applied before any decrement in the same cycle
  assign eff  = (start_hit && valid_q) ? rld_q : cnt_q;
  assign take = sig_hit && valid_q && !cfg_hit && (eff != '0) && !((eff == ONE) && pend_q);
  assign drop = sig_hit && !cfg_hit && !take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      cnt_q   <= '0;
      rld_q   <= '0;
      fid_q   <= '0;
      cid_q   <= '0;
      pend_q  <= 1'b0;
    end else if (cfg_hit) begin
      valid_q <= 1'b1;
      cnt_q   <= cfg_sync;
      rld_q   <= cfg_reset;
      fid_q   <= cfg_fid;
      cid_q   <= cfg_cid;
      pend_q  <= 1'b0;
    end else begin
      if (valid_q) cnt_q <= take ? eff - ONE : eff;
      if (grant) pend_q <= 1'b0;
      if (take && (eff == ONE)) pend_q <= 1'b1;
    end
  end

  assign pend = pend_q;
  assign fid  = fid_q;
  assign cid  = cid_q;

  // R3: a new event only ever appears with the count at zero
  p_fire_at_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> (cnt_q == '0));

  // R5: without a reload or a write the count never rises
  p_cnt_no_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_hit && !start_hit) |=> (cnt_q <= $past(cnt_q)));

  // R7: a pending event survives until granted or overwritten
  p_pend_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !grant && !cfg_hit) |=> pend_q);
endmodule

// File: rtl/sync_enable_arb.sv
module sync_enable_arb #(
  parameter int unsigned N     = 16,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     pend,
  input  logic             ready,
  output logic             valid,
  output logic [IDX_W-1:0] sel,
  output logic [N-1:0]     grant
);
  logic             locked_q;
  logic [IDX_W-1:0] lock_q;
  logic [IDX_W-1:0] low;

  always_comb begin
    low = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) low = IDX_W'(i);
    end
  end

  assign sel   = (locked_q && pend[lock_q]) ? lock_q : low;
  assign valid = pend[sel];

  always_comb begin
    grant      = '0;
    grant[sel] = valid && ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      lock_q   <= '0;
    end else begin
      locked_q <= valid && !ready;
      lock_q   <= sel;
    end
  end

  // R8: at most one slot is granted per cycle
  p_grant_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
endmodule

// File: rtl/sync_slot_bank.sv
module sync_slot_bank
  import sync_bank_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = SB_SLOTS,
  parameter int unsigned CNT_W     = SB_CNT_W,
  parameter int unsigned FID_W     = SB_FID_W,
  parameter int unsigned CID_W     = SB_CID_W,
  localparam int unsigned IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [CNT_W-1:0] cfg_sync,
  input  logic [CNT_W-1:0] cfg_reset,
  input  logic [FID_W-1:0] cfg_fid,
  input  logic [CID_W-1:0] cfg_cid,
  input  logic             sig_valid,
  input  logic [IDX_W-1:0] sig_idx,
  input  logic             start_valid,
  input  logic [IDX_W-1:0] start_idx,
  output logic             en_valid,
  input  logic             en_ready,
  output logic [IDX_W-1:0] en_slot,
  output logic [FID_W-1:0] en_fid,
  output logic [CID_W-1:0] en_cid,
  output logic             err_pulse
);
  logic [NUM_SLOTS-1:0] pend;
  logic [NUM_SLOTS-1:0] grant;
  logic [NUM_SLOTS-1:0] drop;
  logic [FID_W-1:0]     slot_fid [NUM_SLOTS];
  logic [CID_W-1:0]     slot_cid [NUM_SLOTS];
  logic [IDX_W-1:0]     sel;
  logic                 err_q;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    sync_slot #(
      .CNT_W(CNT_W), .FID_W(FID_W), .CID_W(CID_W)
    ) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_hit  (cfg_we && (cfg_idx == IDX_W'(s))),
      .cfg_sync (cfg_sync),
      .cfg_reset(cfg_reset),
      .cfg_fid  (cfg_fid),
      .cfg_cid  (cfg_cid),
      .sig_hit  (sig_valid && (sig_idx == IDX_W'(s))),
      .start_hit(start_valid && (start_idx == IDX_W'(s))),
      .grant    (grant[s]),
      .pend     (pend[s]),
      .fid      (slot_fid[s]),
      .cid      (slot_cid[s]),
      .drop     (drop[s])
    );
  end

  sync_enable_arb #(.N(NUM_SLOTS), .IDX_W(IDX_W)) u_arb (
    .clk  (clk),
    .rst_n(rst_n),
    .pend (pend),
    .ready(en_ready),
    .valid(en_valid),
    .sel  (sel),
    .grant(grant)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= |drop;
  end

  assign en_slot   = sel;
  assign en_fid    = slot_fid[sel];
  assign en_cid    = slot_cid[sel];
  assign err_pulse = err_q;

  // R7: a stalled event stays put unless its slot is rewritten
  p_hold_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_valid && !en_ready && !(cfg_we && cfg_idx == en_slot))
      |=> (en_valid && $stable(en_slot)));

  // R4: an error needs a dependency signal in the cycle before
  p_err_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(sig_valid));
endmodule

// File: tb/sync_slot_bank_tb.sv
module sync_slot_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_idx = '0;
  logic [7:0] cfg_sync = '0, cfg_reset = '0, cfg_fid = '0;
  logic [5:0] cfg_cid = '0;
  logic       sig_valid = 1'b0;
  logic [3:0] sig_idx = '0;
  logic       start_valid = 1'b0;
  logic [3:0] start_idx = '0;
  logic       en_ready = 1'b0;
  logic       en_valid, err_pulse;
  logic [3:0] en_slot;
  logic [7:0] en_fid;
  logic [5:0] en_cid;

  int n_chk = 0, n_bad = 0;
  bit cmp_on = 1'b0;

  sync_slot_bank u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_sync(cfg_sync), .cfg_reset(cfg_reset), .cfg_fid(cfg_fid), .cfg_cid(cfg_cid),
    .sig_valid(sig_valid), .sig_idx(sig_idx), .start_valid(start_valid),
    .start_idx(start_idx), .en_valid(en_valid), .en_ready(en_ready),
    .en_slot(en_slot), .en_fid(en_fid), .en_cid(en_cid), .err_pulse(err_pulse)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // behavioural reference
  int m_valid[NS], m_cnt[NS], m_rld[NS], m_fid[NS], m_cid[NS], m_pend[NS];
  int m_locked, m_lock, m_err;

  function automatic int m_sel();
    if (m_locked != 0 && m_pend[m_lock] != 0) return m_lock;
    for (int i = 0; i < NS; i++) if (m_pend[i] != 0) return i;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) begin
        m_valid[i] = 0; m_cnt[i] = 0; m_rld[i] = 0; m_fid[i] = 0; m_cid[i] = 0; m_pend[i] = 0;
      end
      m_locked = 0; m_lock = 0; m_err = 0;
    end else begin
      int sel, ev, hs, e, take, fire;
      sel = m_sel();
      ev = m_pend[sel];
      hs = (ev != 0) && en_ready;
      m_err = 0; take = 0; fire = 0; e = 0;
      if (sig_valid && !(cfg_we && cfg_idx == sig_idx)) begin
        e = (start_valid && start_idx == sig_idx && m_valid[sig_idx] != 0) ? m_rld[sig_idx] : m_cnt[sig_idx];
        if (m_valid[sig_idx] != 0 && e != 0 && !(e == 1 && m_pend[sig_idx] != 0)) begin
          take = 1; fire = (e == 1);
        end else m_err = 1;
      end
      if (start_valid && !(cfg_we && cfg_idx == start_idx) && m_valid[start_idx] != 0)
        m_cnt[start_idx] = m_rld[start_idx];
      if (take != 0) m_cnt[sig_idx] = e - 1;
      if (hs) m_pend[sel] = 0;
      if (fire != 0) m_pend[sig_idx] = 1;
      if (cfg_we) begin
        m_valid[cfg_idx] = 1; m_cnt[cfg_idx] = cfg_sync; m_rld[cfg_idx] = cfg_reset;
        m_fid[cfg_idx] = cfg_fid; m_cid[cfg_idx] = cfg_cid; m_pend[cfg_idx] = 0;
      end
      m_locked = (ev != 0) && !en_ready;
      m_lock = sel;
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (cmp_on) begin
      int s;
      s = m_sel();
      n_chk++;
      if (en_valid !== (m_pend[s] != 0)) begin
        n_bad++; $display("FAIL R7 en_valid actual %0b expected %0b", en_valid, m_pend[s] != 0);
      end else if (en_valid && (en_slot !== 4'(s) || en_fid !== 8'(m_fid[s]) || en_cid !== 6'(m_cid[s]))) begin
        n_bad++;
        $display("FAIL R8 slot/fid/cid actual %0d/%0h/%0h expected %0d/%0h/%0h",
                 en_slot, en_fid, en_cid, s, m_fid[s], m_cid[s]);
      end
      n_chk++;
      if (err_pulse !== (m_err != 0)) begin
        n_bad++; $display("FAIL R4 err_pulse actual %0b expected %0b", err_pulse, m_err != 0);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++; $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr();
    cfg_we = 0; sig_valid = 0; start_valid = 0;
  endtask

  task automatic cfg(input int idx, input int sc, input int rc, input int f, input int c);
    cfg_we = 1; cfg_idx = 4'(idx); cfg_sync = 8'(sc); cfg_reset = 8'(rc);
    cfg_fid = 8'(f); cfg_cid = 6'(c);
    @(negedge clk); clr();
  endtask

  task automatic sig(input int idx);
    sig_valid = 1; sig_idx = 4'(idx);
    @(negedge clk); clr();
  endtask

  task automatic start_sig(input int idx);
    start_valid = 1; start_idx = 4'(idx); sig_valid = 1; sig_idx = 4'(idx);
    @(negedge clk); clr();
  endtask

  task automatic accept();
    en_ready = 1; @(negedge clk); en_ready = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cmp_on = 1;
    // R1
    chk("R1 en_valid", int'(en_valid), 0);
    chk("R1 err_pulse", int'(err_pulse), 0);

    // R3 countdown, R4 drops, R7 stall
    cfg(3, 2, 2, 8'h11, 5);
    sig(3);
    chk("R3 early fire", int'(en_valid), 0);
    sig(3);
    chk("R3 en_valid", int'(en_valid), 1);
    chk("R3 en_slot", int'(en_slot), 3);
    chk("R3 en_fid", int'(en_fid), 8'h11);
    chk("R3 en_cid", int'(en_cid), 5);
    sig(3);
    chk("R4 zero-count drop", int'(err_pulse), 1);
    chk("R7 held", int'(en_valid), 1);
    sig(7);
    chk("R4 invalid-slot drop", int'(err_pulse), 1);
    accept();
    chk("R7 after handshake", int'(en_valid), 0);

    // R5 reload then decrement
    start_sig(3);
    chk("R5 no fire at reload 2", int'(en_valid), 0);
    chk("R5 no error", int'(err_pulse), 0);
    sig(3);
    chk("R5 fire after reload", int'(en_valid), 1);
    accept();
    cfg(6, 1, 1, 8'h66, 12);
    sig(6);
    chk("R5 first fire", int'(en_slot), 6);
    accept();
    start_sig(6);
    chk("R5 reload 1 fires at once", int'(en_valid), 1);
    chk("R5 slot", int'(en_slot), 6);
    accept();

    // R6 and R8: two slots on one codelet, stalled consumer
    cfg(1, 1, 1, 8'h21, 9);
    cfg(2, 1, 1, 8'h22, 9);
    sig(2);
    chk("R6 slot 2 fires", int'(en_slot), 2);
    sig(1);
    chk("R8 held over lower slot", int'(en_slot), 2);
    chk("R6 cid", int'(en_cid), 9);
    accept();
    chk("R8 next slot", int'(en_slot), 1);
    chk("R6 second event", int'(en_fid), 8'h21);
    accept();
    chk("R7 drained", int'(en_valid), 0);

    // R9 zero initial count
    cfg(5, 0, 3, 8'h55, 1);
    sig(5);
    chk("R9 drop at zero", int'(err_pulse), 1);
    chk("R9 no event", int'(en_valid), 0);
    start_valid = 1; start_idx = 4'd5; @(negedge clk); clr();
    sig(5); sig(5);
    chk("R9 not yet", int'(en_valid), 0);
    sig(5);
    chk("R9 fires after reload", int'(en_slot), 5);
    accept();

    // R2 write overrides same-cycle signal
    cfg_we = 1; cfg_idx = 4'd4; cfg_sync = 8'd2; cfg_reset = 8'd2; cfg_fid = 8'h44; cfg_cid = 6'd4;
    sig_valid = 1; sig_idx = 4'd4;
    @(negedge clk); clr();
    chk("R2 no error on collision", int'(err_pulse), 0);
    sig(4);
    chk("R2 count loaded", int'(en_valid), 0);
    sig(4);
    chk("R2 fires", int'(en_slot), 4);
    chk("R2 fid", int'(en_fid), 8'h44);
    accept();

    // random mix compared against the model every cycle
    for (int k = 0; k < 4000; k++) begin
      cfg_we      = ($urandom_range(0, 15) == 0);
      cfg_idx     = 4'($urandom_range(0, 7));
      cfg_sync    = 8'($urandom_range(0, 3));
      cfg_reset   = 8'($urandom_range(0, 3));
      cfg_fid     = 8'($urandom);
      cfg_cid     = 6'($urandom);
      sig_valid   = ($urandom_range(0, 1) == 1);
      sig_idx     = 4'($urandom_range(0, 8));
      start_valid = ($urandom_range(0, 3) == 0);
      start_idx   = 4'($urandom_range(0, 8));
      en_ready    = ($urandom_range(0, 2) != 0);
      @(negedge clk);
    end
    clr(); en_ready = 0;
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule